// File: doc/BRIEF.md
# Secure Event Observation Filter

This block holds one 64-bit observation control word for each unit in a bank of system performance monitors. It also decides, for every event that reaches a unit, whether that event may be counted. Software picks a unit with a selector index and then reads or writes that unit's control word. Each event arrives with a 2-bit security tag. The filter combines the tag with the selected unit's stored control bits and with an external root-level enable for unattributed events, and returns a count-enable in the same cycle.

The event side is a stream with a valid strobe only. The filter never applies back-pressure and takes one event per unit in every cycle, so there is no ready signal. A cycle with valid low carries no event. The register side is a plain write strobe with a read path. The read path is combinational on the selector index.

Unit presence, register presence and the optional unattributed-observation bit are set per unit through parameters. The reset value of the upper 32 implementation-defined bits is also a parameter. With the defaults the units are set up as follows:
- unit 0 is complete;
- unit 1 lacks bit 4;
- unit 2 is present but has no control register;
- unit 3 is absent;
- selector values 4 to 7 select no unit.

Top module: `seo_filter`

## Requirements
- R1: After reset, an implemented control word reads as 0xA5A5_0000_8000_0000: the upper 32 bits hold the parameter reset value, bit 31 reads 1, and every other bit is 0.
- R2: In an implemented word, bits 63:32, bit 4 (if present) and bit 0 are writable. Bits 30:5 and 3:1 always read 0. Bit 31 always reads 1, whatever is written.
- R3: A write changes the stored word at the clock edge that samples the write strobe. An event in that same cycle is filtered with the old value.
- R4: An event with tag 01 (secure) counts only when bit 0 of its unit is 1.
- R5: A valid event with tag 00 (non-secure) counts in every present unit, whatever the control bits are.
- R6: An event with tag 10 (unattributed) counts only when the root enable is 1 and at least one of bit 4 and bit 0 is 1.
- R7: In a unit without bit 4, bit 4 reads 0 and ignores writes. Unattributed events in that unit are then governed by bit 0 and the root enable alone.
- R8: The whole word reads as zero and ignores writes in three cases: when the selected unit is absent, when it has no control register, or when the index is out of range. A unit without a register filters as if all its bits were 0. An absent unit never counts.
- R9: A unit with valid low gives no count-enable. Tag 11 never counts.
- R10: A write changes only the unit named by the selector index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | SEL_W | Unit selector index for reads and writes |
| cfg_wr | input | 1 | Write strobe for the selected unit |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data of the selected unit |
| root_nae_en | input | 1 | Root-level enable for unattributed events |
| ev_valid | input | NUM_UNITS | Event valid, one per unit |
| ev_tag | input | 2*NUM_UNITS | Security tag per unit: 00 non-secure, 01 secure, 10 unattributed, 11 reserved |
| ev_cnt_en | output | NUM_UNITS | Count-enable per unit, same cycle as the event |

## Verification
The gate is tested against a table that varies the root enable, bit 0, bit 4, valid and all four tags. This separates three things: the secure path, which depends only on bit 0; the unattributed path, which needs both the root enable and the OR of the two local bits; and the non-secure path, which is unconditional.

Directed cases cover the rest:
- the write-cycle event that must still see the old word;
- a unit without bit 4, whose written 1 must be dropped;
- units without a register, absent units and out-of-range indices, which must read as zero;
- a write that must not leak into a neighbouring unit.

// File: rtl/seo_pkg.sv
package seo_pkg;
  typedef enum logic [1:0] {
    TAG_NSEC  = 2'b00,
    TAG_SEC   = 2'b01,
    TAG_NATTR = 2'b10,
    TAG_RSVD  = 2'b11
  } seo_tag_e;

  localparam int WORD_W   = 64;
  localparam int SO_POS   = 0;
  localparam int NAO_POS  = 4;
  localparam int ONE_POS  = 31;
  localparam int IMPL_LSB = 32;
  localparam int IMPL_W   = WORD_W - IMPL_LSB;

  typedef struct packed {
    logic nao;
    logic so;
  } seo_ctl_t;
endpackage

// File: rtl/seo_unit_reg.sv
module seo_unit_reg
  import seo_pkg::*;
#(
  parameter bit                PRESENT  = 1'b1,
  parameter bit                HAS_REG  = 1'b1,
  parameter bit                HAS_NAO  = 1'b1,
  parameter logic [IMPL_W-1:0] IMPL_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output seo_ctl_t          ctl
);
  localparam bit LIVE = PRESENT && HAS_REG;

  generate
    if (LIVE) begin : g_live
      logic              so_q;
      logic [IMPL_W-1:0] impl_q;
      logic              nao_r;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          so_q   <= 1'b0;
          impl_q <= IMPL_RST;
        end else if (wr_en) begin
          so_q   <= wdata[SO_POS];
          impl_q <= wdata[WORD_W-1:IMPL_LSB];
        end
      end

      if (HAS_NAO) begin : g_nao
        logic nao_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     nao_q <= 1'b0;
          else if (wr_en) nao_q <= wdata[NAO_POS];
        end
        assign nao_r = nao_q;
      end else begin : g_no_nao
        assign nao_r = 1'b0;
      end

      always_comb begin
        rdata                        = '0;
        rdata[WORD_W-1:IMPL_LSB]     = impl_q;
        rdata[ONE_POS]               = 1'b1;
        rdata[NAO_POS]               = nao_r;
        rdata[SO_POS]                = so_q;
      end
      assign ctl.so  = so_q;
      assign ctl.nao = nao_r;
    end else begin : g_dead
      assign rdata   = '0;
      assign ctl.so  = 1'b0;
      assign ctl.nao = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/seo_gate.sv
module seo_gate
  import seo_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic     valid,
  input  logic [1:0] tag,
  input  seo_ctl_t ctl,
  input  logic     root_nae_en,
  output logic     cnt_en
);
  logic allow;

  always_comb begin
    case (seo_tag_e'(tag))
      TAG_NSEC:  allow = 1'b1;
      TAG_SEC:   allow = ctl.so;
      TAG_NATTR: allow = root_nae_en && (ctl.nao || ctl.so);
      default:   allow = 1'b0;
    endcase
  end

  generate
    if (PRESENT) begin : g_on
      assign cnt_en = valid && allow;
    end else begin : g_off
      assign cnt_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/seo_rd_mux.sv
module seo_rd_mux
  import seo_pkg::*;
#(
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]    sel,
  input  logic [N*WORD_W-1:0] words,
  output logic [WORD_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) rdata = words[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/seo_filter.sv
module seo_filter
  import seo_pkg::*;
#(
  parameter int                NUM_UNITS  = 4,
  parameter int                SEL_W      = 3,
  parameter logic [NUM_UNITS-1:0] UNIT_PRESENT = 4'b0111,
  parameter logic [NUM_UNITS-1:0] UNIT_HAS_REG = 4'b0011,
  parameter logic [NUM_UNITS-1:0] UNIT_HAS_NAO = 4'b0001,
  parameter logic [IMPL_W-1:0] IMPL_RST   = 32'hA5A5_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic                   cfg_wr,
  input  logic [WORD_W-1:0]      cfg_wdata,
  output logic [WORD_W-1:0]      cfg_rdata,
  input  logic                   root_nae_en,
  input  logic [NUM_UNITS-1:0]   ev_valid,
  input  logic [2*NUM_UNITS-1:0] ev_tag,
  output logic [NUM_UNITS-1:0]   ev_cnt_en
);
  logic [NUM_UNITS*WORD_W-1:0] words;
  logic [NUM_UNITS-1:0]        ctl_so;
  logic [NUM_UNITS-1:0]        ctl_nao;

  generate
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
      seo_ctl_t ctl;
      logic     wr_hit;
      assign wr_hit = cfg_wr && (cfg_sel == SEL_W'(i));

      seo_unit_reg #(
        .PRESENT (UNIT_PRESENT[i]),
        .HAS_REG (UNIT_HAS_REG[i]),
        .HAS_NAO (UNIT_HAS_NAO[i]),
        .IMPL_RST(IMPL_RST)
      ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_hit),
        .wdata(cfg_wdata),
        .rdata(words[i*WORD_W +: WORD_W]),
        .ctl  (ctl)
      );

      seo_gate #(.PRESENT(UNIT_PRESENT[i])) u_gate (
        .valid      (ev_valid[i]),
        .tag        (ev_tag[2*i +: 2]),
        .ctl        (ctl),
        .root_nae_en(root_nae_en),
        .cnt_en     (ev_cnt_en[i])
      );

      assign ctl_so[i]  = ctl.so;
      assign ctl_nao[i] = ctl.nao;
    end
  endgenerate

  seo_rd_mux #(.N(NUM_UNITS), .SEL_W(SEL_W)) u_mux (
    .sel  (cfg_sel),
    .words(words),
    .rdata(cfg_rdata)
  );
endmodule

// File: rtl/seo_filter_chk.sv
module seo_filter_chk #(
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [63:0]      cfg_rdata,
  input logic             root_nae_en,
  input logic [N-1:0]     ev_valid,
  input logic [2*N-1:0]   ev_tag,
  input logic [N-1:0]     ev_cnt_en,
  input logic [N-1:0]     ctl_so,
  input logic [N-1:0]     ctl_nao
);
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[30:5] == '0) && (cfg_rdata[3:1] == '0)); // R2

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      AST_SEC_NEEDS_SO: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid[i] && ev_tag[2*i +: 2] == 2'b01 && ev_cnt_en[i]) |-> ctl_so[i]); // R4
      AST_NATTR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid[i] && ev_tag[2*i +: 2] == 2'b10 && ev_cnt_en[i])
          |-> (root_nae_en && (ctl_so[i] || ctl_nao[i]))); // R6
      AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid[i] || ev_tag[2*i +: 2] == 2'b11) |-> !ev_cnt_en[i]); // R9
      AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr || cfg_sel != SEL_W'(i)) |=> $stable({ctl_so[i], ctl_nao[i]})); // R10
    end
  endgenerate
endmodule

bind seo_filter seo_filter_chk #(.N(NUM_UNITS), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_sel    (cfg_sel),
  .cfg_rdata  (cfg_rdata),
  .root_nae_en(root_nae_en),
  .ev_valid   (ev_valid),
  .ev_tag     (ev_tag),
  .ev_cnt_en  (ev_cnt_en),
  .ctl_so     (ctl_so),
  .ctl_nao    (ctl_nao)
);

// File: tb/seo_filter_bench.sv
module seo_filter_bench;
  localparam int N = 4;
  localparam int SEL_W = 3;
  localparam int NV = 14;
  // {root, so, nao, valid, tag[1:0], expected}
  localparam logic [6:0] VEC [NV] = '{
    7'b0001001, 7'b0001010, 7'b0101011, 7'b1001100,
    7'b1101101, 7'b1011101, 7'b0111100, 7'b1111110,
    7'b1110000, 7'b1110010, 7'b0011010, 7'b1111011,
    7'b1011001, 7'b0011100
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic             cfg_wr = 1'b0;
  logic [63:0]      cfg_wdata = '0;
  logic [63:0]      cfg_rdata;
  logic             root_nae_en = 1'b0;
  logic [N-1:0]     ev_valid = '0;
  logic [2*N-1:0]   ev_tag = '0;
  logic [N-1:0]     ev_cnt_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seo_filter u_seo_filter (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .root_nae_en(root_nae_en),
    .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_cnt_en(ev_cnt_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [63:0] d);
    @(negedge clk);
    cfg_sel = SEL_W'(sel); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int sel, input logic [63:0] exp);
    cfg_sel = SEL_W'(sel);
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic ev(input string req, input int u, input logic v,
                    input logic [1:0] t, input logic exp);
    @(negedge clk);
    ev_valid = '0; ev_tag = '0;
    ev_valid[u] = v; ev_tag[2*u +: 2] = t;
    #1;
    check(req, 64'(ev_cnt_en[u]), 64'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd("R1 unit0 reset", 0, 64'hA5A5_0000_8000_0000);
    rd("R1 unit1 reset", 1, 64'hA5A5_0000_8000_0000);
    // table walk on unit 0 (R4 R5 R6 R9)
    for (int k = 0; k < NV; k++) begin
      wr(0, {32'h0, 27'h0, VEC[k][4], 3'b0, VEC[k][5]});
      root_nae_en = VEC[k][6];
      ev("R4/R5/R6/R9 table", 0, VEC[k][3], VEC[k][2:1], VEC[k][0]);
    end
    ev_valid = '0;
    // R2 writable and fixed bits
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R2 all ones", 0, 64'hFFFF_FFFF_8000_0011);
    wr(0, 64'h1234_5678_0000_0000);
    rd("R2 all zero low", 0, 64'h1234_5678_8000_0000);
    // R3 same-cycle write uses old value
    @(negedge clk);
    cfg_sel = 3'd0; cfg_wr = 1'b1; cfg_wdata = 64'h1;
    ev_valid = 4'b0001; ev_tag = 8'b01;
    #1;
    check("R3 old value in write cycle", 64'(ev_cnt_en[0]), 64'd0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R3 new value after edge", 64'(ev_cnt_en[0]), 64'd1);
    // R7 unit without bit 4
    wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R7 bit4 dropped", 1, 64'hFFFF_FFFF_8000_0001);
    root_nae_en = 1'b1;
    ev("R7 unattr via so", 1, 1'b1, 2'b10, 1'b1);
    wr(1, 64'h10);
    rd("R7 bit4 write ignored", 1, 64'h0000_0000_8000_0000);
    ev("R7 unattr blocked", 1, 1'b1, 2'b10, 1'b0);
    // R10 other unit untouched
    wr(0, 64'hDEAD_BEEF_0000_0011);
    rd("R10 neighbour unchanged", 1, 64'h0000_0000_8000_0000);
    rd("R10 target written", 0, 64'hDEAD_BEEF_8000_0011);
    // R8 missing register / unit / index
    wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R8 no-reg unit", 2, 64'h0);
    wr(3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R8 absent unit", 3, 64'h0);
    wr(5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R8 out of range", 5, 64'h0);
    rd("R8 unit0 untouched", 0, 64'hDEAD_BEEF_8000_0011);
    ev("R8 no-reg nonsecure", 2, 1'b1, 2'b00, 1'b1);
    ev("R8 no-reg secure", 2, 1'b1, 2'b01, 1'b0);
    ev("R8 no-reg unattr", 2, 1'b1, 2'b10, 1'b0);
    ev("R8 absent unit", 3, 1'b1, 2'b00, 1'b0);
    // R5 nonsecure with everything off
    wr(0, 64'h0);
    root_nae_en = 1'b0;
    ev("R5 nonsecure all off", 0, 1'b1, 2'b00, 1'b1);
    // reset returns defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 after second reset", 0, 64'hA5A5_0000_8000_0000);
    finish_run();
  end
endmodule